// File: doc/BRIEF.md
# Video Control Register Slave on a Two-Wire Serial Bus

This block receives control settings for a video signal processor from a host over a two-wire serial bus (I2C, write direction only). It oversamples the bus clock and data lines with the system clock and finds start and stop conditions. It answers only to its own 7-bit device address with the read/write bit clear. The second byte of a transfer selects a register. The bytes after it are written into a bank of 6-bit picture-adjustment registers and 8-bit control registers.

One control register, the mode register, sets two things. It chooses whether the register selection advances after each data byte. It also chooses whether new values reach the outputs at once or wait in shadow copies until the next rising edge of the vertical-blanking input. At that edge every staged value is applied in the same cycle, so a change that spans several registers never appears part-way through a picture.

The outputs are the live register values as flat parallel vectors, for the analog converters and the mode logic downstream. The bus pins carry a wire protocol, not a stream, and the bus clock is never held low. The only output on the bus side is an open-drain enable for the data line.

Top module: `vidctl_i2c_slave`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Between a stop and the next start, bytes clocked on the bus are neither acknowledged nor written.
- R2: The first byte after a start is acknowledged only when it equals 0x88 (device address 0x44 with the read/write bit 0). Any other value, including 0x89, is not acknowledged, and the rest of that transfer is ignored until the next start.
- R3: For each accepted byte, `sda_oe_o` goes high after the clock line falls following the eighth bit. It stays high through the ninth clock pulse and is released when the clock line next falls. For a byte that is not accepted, `sda_oe_o` stays low.
- R4: Sub-addresses 0x00 to 0x07 select eight adjustment registers, which store the low 6 bits of the data byte. Adjustment register n is `adj_o[6n+5:6n]`. Sub-address 0x09 selects an 8-bit auxiliary register at `ctl_o[15:8]`.
- R5: Bit 0 of the mode register is the auto-increment disable flag. While it is 0, each data byte after the sub-address goes to the next sub-address in turn, wrapping from 0xFF to 0x00, and the number of data bytes is unlimited.
- R6: While the auto-increment disable flag is 1, only the first data byte after the sub-address is written. Later data bytes in the same transfer are not acknowledged and are not written.
- R7: A data byte aimed at a sub-address from 0x0A to 0xFF is acknowledged but changes no register.
- R8: Bit 1 of the mode register is the blanking-sync flag. While it is 1, writes to the adjustment and auxiliary registers are staged and the outputs hold their values. On a rising edge of `vblank_i`, all staged values appear on the outputs together, one clock edge after the edge is sampled.
- R9: The mode register at sub-address 0x08 (`ctl_o[7:0]`) always takes a write at once, whether or not blanking sync is on.
- R10: A start that arrives in the middle of a transfer (a repeated start) begins a new transfer, and the next byte is treated as a device address.
- R11: After reset, every register output and `sda_oe_o` is 0.
- R12: A written value reaches its output on the fifth rising `clk` edge after `scl_i` is first seen high for the eighth bit of the data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_o | output | 1 | When high, the data line is pulled low (acknowledge) |
| vblank_i | input | 1 | Vertical-blanking pulse, synchronous to clk; its rising edge applies staged values |
| adj_o | output | 48 | Eight 6-bit adjustment registers, register n at bits 6n+5:6n |
| ctl_o | output | 16 | Mode register in bits 7:0, auxiliary control register in bits 15:8 |

## Verification
Each result has a fixed latency in clock edges. A register write appears after the fifth rising edge following the bus-clock rise that carries the last bit of the data byte. The acknowledge enable rises three edges after the bus clock falls. A blanking-edge transfer appears one edge after `vblank_i` is raised.

The bench drives its bus inputs on falling clock edges. Its behavioural model applies each expected write exactly five rising edges after that drive, and each blanking copy one rising edge after it. On every falling edge, both register output vectors are compared with the model. This per-cycle comparison catches a write that lands early or late as well as a wrong value. Acknowledge checks are sampled in the middle of the ninth clock pulse, well after the enable has settled.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;

  localparam int BYTE_W         = 8;
  localparam int MODE_AIDIS_BIT = 0;
  localparam int MODE_SYNC_BIT  = 1;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA,
    PH_SKIP
  } phase_e;

endpackage

// File: rtl/vidctl_line_sync.sv
module vidctl_line_sync #(
  parameter int NLINE  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] raw_i,
  output logic [NLINE-1:0] lvl_o,
  output logic [NLINE-1:0] prev_o
);

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-1:0], raw_i[g]};
    end

    assign lvl_o[g]  = pipe_q[STAGES-1];
    assign prev_o[g] = pipe_q[STAGES];
  end

endmodule

// File: rtl/vidctl_bit_rx.sv
module vidctl_bit_rx
  import vidctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              scl_d,
  input  logic              sda_s,
  input  logic              sda_d,
  input  logic              ack_ok_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              sda_oe_o
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic              in_frame_q;
  logic              in_ack_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-2:0] shreg_q;
  logic              scl_rise, scl_fall;

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_o  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o   = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      in_ack_q   <= 1'b0;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      sda_oe_o   <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (start_o) begin
        in_frame_q <= 1'b1;
        in_ack_q   <= 1'b0;
        bit_cnt_q  <= '0;
        sda_oe_o   <= 1'b0;
      end else if (stop_o) begin
        in_frame_q <= 1'b0;
        in_ack_q   <= 1'b0;
        bit_cnt_q  <= '0;
        sda_oe_o   <= 1'b0;
      end else if (in_frame_q) begin
        if (scl_rise && !in_ack_q && bit_cnt_q != CNT_W'(BYTE_W)) begin
          shreg_q <= {shreg_q[BYTE_W-3:0], sda_s};
          if (bit_cnt_q == CNT_W'(BYTE_W - 1)) begin
            byte_vld_o <= 1'b1;
            byte_o     <= {shreg_q, sda_s};
          end
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (scl_fall) begin
          if (in_ack_q) begin
            in_ack_q  <= 1'b0;
            sda_oe_o  <= 1'b0;
            bit_cnt_q <= '0;
          end else if (bit_cnt_q == CNT_W'(BYTE_W)) begin
            in_ack_q <= 1'b1;
            sda_oe_o <= ack_ok_i;
          end
        end
      end
    end
  end

  // R3: acknowledge drive only starts while the bus clock is low
  assert_ack_on_low_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_s);

  // R1: no byte is delivered outside a transfer
  assert_idle_no_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame_q |=> !byte_vld_o);

endmodule

// File: rtl/vidctl_frame_dec.sv
module vidctl_frame_dec
  import vidctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              aidis_i,
  output logic              ack_ok_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);

  phase_e            phase_q;
  logic [BYTE_W-1:0] sub_q;
  logic              first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      sub_q     <= '0;
      first_q   <= 1'b0;
      ack_ok_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        phase_q  <= PH_ADDR;
        ack_ok_o <= 1'b0;
      end else if (stop_i) begin
        phase_q  <= PH_IDLE;
        ack_ok_o <= 1'b0;
      end else if (byte_vld_i) begin
        unique case (phase_q)
          PH_ADDR: begin
            if (byte_i == {DEV_ADDR, 1'b0}) begin
              phase_q  <= PH_SUB;
              ack_ok_o <= 1'b1;
            end else begin
              phase_q  <= PH_SKIP;
              ack_ok_o <= 1'b0;
            end
          end
          PH_SUB: begin
            sub_q    <= byte_i;
            first_q  <= 1'b1;
            phase_q  <= PH_DATA;
            ack_ok_o <= 1'b1;
          end
          PH_DATA: begin
            if (aidis_i && !first_q) begin
              ack_ok_o <= 1'b0;
            end else begin
              wr_en_o   <= 1'b1;
              wr_addr_o <= sub_q;
              wr_data_o <= byte_i;
              first_q   <= 1'b0;
              ack_ok_o  <= 1'b1;
              if (!aidis_i) sub_q <= sub_q + 1'b1;
            end
          end
          default: ack_ok_o <= 1'b0;
        endcase
      end
    end
  end

  // R2: a refused or idle transfer never produces a write
  assert_skip_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKIP || phase_q == PH_IDLE) |=> !wr_en_o);

  // R6: with auto-increment off, a second data byte is neither written nor acknowledged
  assert_single_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && phase_q == PH_DATA && aidis_i && !first_q) |=> (!wr_en_o && !ack_ok_o));

endmodule

// File: rtl/vidctl_reg_bank.sv
module vidctl_reg_bank
  import vidctl_pkg::*;
#(
  parameter int NUM_ADJ = 8,
  parameter int ADJ_W   = 6,
  parameter int NUM_CTL = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [BYTE_W-1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0]        wr_data_i,
  input  logic                     vblank_i,
  output logic [NUM_ADJ*ADJ_W-1:0] adj_o,
  output logic [NUM_CTL*BYTE_W-1:0] ctl_o,
  output logic                     aidis_o
);

  localparam int CTL_BASE  = NUM_ADJ;
  localparam int MODE_ADDR = CTL_BASE;
  localparam int LAST_ADDR = CTL_BASE + NUM_CTL - 1;

  logic vb_q, vb_rise, sync_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vb_q <= 1'b0;
    else        vb_q <= vblank_i;
  end

  assign vb_rise = vblank_i & ~vb_q;
  assign sync_en = ctl_o[MODE_SYNC_BIT];
  assign aidis_o = ctl_o[MODE_AIDIS_BIT];

  for (genvar g = 0; g < NUM_ADJ; g++) begin : g_adj
    logic [ADJ_W-1:0] act_q, shd_q;
    logic             hit;
    assign hit = wr_en_i && (wr_addr_i == BYTE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= '0;
        shd_q <= '0;
      end else begin
        if (vb_rise) act_q <= shd_q;
        if (hit) begin
          shd_q <= wr_data_i[ADJ_W-1:0];
          if (!sync_en) act_q <= wr_data_i[ADJ_W-1:0];
        end
      end
    end

    assign adj_o[g*ADJ_W +: ADJ_W] = act_q;
  end

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
    logic [BYTE_W-1:0] act_q;
    logic              hit;
    assign hit = wr_en_i && (wr_addr_i == BYTE_W'(CTL_BASE + g));

    if (g == 0) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   act_q <= '0;
        else if (hit) act_q <= wr_data_i;
      end
    end else begin : g_aux
      logic [BYTE_W-1:0] shd_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          act_q <= '0;
          shd_q <= '0;
        end else begin
          if (vb_rise) act_q <= shd_q;
          if (hit) begin
            shd_q <= wr_data_i;
            if (!sync_en) act_q <= wr_data_i;
          end
        end
      end
    end

    assign ctl_o[g*BYTE_W +: BYTE_W] = act_q;
  end

  // R8: with blanking sync on, adjustment outputs move only on a blanking edge
  assert_hold_until_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && !vb_rise) |=> $stable(adj_o));

  // R9: the mode register takes a write on the next edge regardless of sync
  assert_mode_immediate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == BYTE_W'(MODE_ADDR)) |=> (ctl_o[BYTE_W-1:0] == $past(wr_data_i)));

  // R7: writes beyond the implemented range change nothing
  assert_unmapped_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i > BYTE_W'(LAST_ADDR) && !vb_rise) |=> ($stable(adj_o) && $stable(ctl_o)));

endmodule

// File: rtl/vidctl_i2c_slave.sv
module vidctl_i2c_slave
  import vidctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44,
  parameter int         NUM_ADJ  = 8,
  parameter int         ADJ_W    = 6,
  parameter int         NUM_CTL  = 2,
  parameter int         SYNC_STG = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe_o,
  input  logic                      vblank_i,
  output logic [NUM_ADJ*ADJ_W-1:0]  adj_o,
  output logic [NUM_CTL*BYTE_W-1:0] ctl_o
);

  logic [1:0]        lvl, prev;
  logic              start, stop, byte_vld, ack_ok, aidis;
  logic [BYTE_W-1:0] byte_val;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr, wr_data;

  vidctl_line_sync #(.NLINE(2), .STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({sda_i, scl_i}),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  vidctl_bit_rx u_bit (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (lvl[0]),
    .scl_d      (prev[0]),
    .sda_s      (lvl[1]),
    .sda_d      (prev[1]),
    .ack_ok_i   (ack_ok),
    .start_o    (start),
    .stop_o     (stop),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_val),
    .sda_oe_o   (sda_oe_o)
  );

  vidctl_frame_dec #(.DEV_ADDR(DEV_ADDR)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .stop_i     (stop),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_val),
    .aidis_i    (aidis),
    .ack_ok_o   (ack_ok),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  vidctl_reg_bank #(.NUM_ADJ(NUM_ADJ), .ADJ_W(ADJ_W), .NUM_CTL(NUM_CTL)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .vblank_i  (vblank_i),
    .adj_o     (adj_o),
    .ctl_o     (ctl_o),
    .aidis_o   (aidis)
  );

endmodule

// File: tb/vidctl_i2c_slave_bench.sv
`timescale 1ns/1ps
module vidctl_i2c_slave_bench;

  localparam int NA = 8;
  localparam int AW = 6;
  localparam int NC = 2;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic vblank = 1'b0;
  logic sda_bus;
  logic sda_oe;
  logic [NA*AW-1:0] adj;
  logic [NC*8-1:0]  ctl;

  assign sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  vidctl_i2c_slave u_vidctl_i2c_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .vblank_i (vblank),
    .adj_o    (adj),
    .ctl_o    (ctl)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;
  bit cmp_on = 0;

  // behavioural reference model
  int e_adj[NA];
  int s_adj[NA];
  int e_ctl[NC];
  int s_ctl[NC];
  int ph = 0;
  int msub = 0;
  bit mfirst = 0;

  function automatic logic [NA*AW-1:0] exp_adj();
    logic [NA*AW-1:0] v;
    for (int i = 0; i < NA; i++) v[i*AW +: AW] = AW'(e_adj[i]);
    return v;
  endfunction

  function automatic logic [NC*8-1:0] exp_ctl();
    logic [NC*8-1:0] v;
    for (int i = 0; i < NC; i++) v[i*8 +: 8] = 8'(e_ctl[i]);
    return v;
  endfunction

  function automatic void mwrite(input int sub, input int b);
    bit sync;
    sync = e_ctl[0][1];
    if (sub < NA) begin
      s_adj[sub] = b & 63;
      if (!sync) e_adj[sub] = b & 63;
    end else if (sub == NA) begin
      e_ctl[0] = b;
      s_ctl[0] = b;
    end else if (sub == NA + 1) begin
      s_ctl[1] = b;
      if (!sync) e_ctl[1] = b;
    end
  endfunction

  function automatic bit model_byte(input logic [7:0] b);
    bit aid;
    aid = e_ctl[0][0];
    case (ph)
      1: begin
        if (b == 8'h88) begin ph = 2; return 1'b1; end
        ph = 4;
        return 1'b0;
      end
      2: begin
        msub = int'(b); mfirst = 1; ph = 3;
        return 1'b1;
      end
      3: begin
        if (aid && !mfirst) return 1'b0;
        mwrite(msub, int'(b));
        mfirst = 0;
        if (!aid) msub = (msub + 1) % 256;
        return 1'b1;
      end
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R12: per-cycle comparison of both register vectors against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      n_chk++;
      if (adj !== exp_adj() || ctl !== exp_ctl()) begin
        n_bad++;
        $display("FAIL R12 cycle %0d adj actual=%h expected=%h ctl actual=%h expected=%h",
                 cyc, adj, exp_adj(), ctl, exp_ctl());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; ph = 1; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; ph = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    bit ack;
    ack = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1;
      if (i == 0) begin
        repeat (5) @(posedge clk);
        ack = model_byte(b);
        tick(2*Q - 1);
      end else begin
        tick(2*Q);
      end
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    check(sda_oe === ack, tag, int'(sda_oe), int'(ack));
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic blank_pulse();
    @(negedge clk);
    vblank = 1'b1;
    @(posedge clk);
    for (int i = 0; i < NA; i++) e_adj[i] = s_adj[i];
    e_ctl[1] = s_ctl[1];
    tick(3);
    vblank = 1'b0;
    tick(2);
  endtask

  function automatic int adj_at(input int i);
    return int'(adj[i*AW +: AW]);
  endfunction

  initial begin
    logic [NA*AW-1:0] snap_a;
    logic [NC*8-1:0]  snap_c;
    for (int i = 0; i < NA; i++) begin e_adj[i] = 0; s_adj[i] = 0; end
    for (int i = 0; i < NC; i++) begin e_ctl[i] = 0; s_ctl[i] = 0; end
    tick(4);
    rst_n = 1'b1;
    tick(1);
    cmp_on = 1;
    check(adj == '0, "R11 reset adj", int'(adj[31:0]), 0);
    check(ctl == '0, "R11 reset ctl", int'(ctl), 0);
    check(sda_oe == 1'b0, "R11 reset sda_oe", int'(sda_oe), 0);
    tick(20);

    // R4 R5: auto-increment burst into adjustment registers
    bus_start();
    send_byte(8'h88, "R2 R3 address ack");
    send_byte(8'h00, "R3 sub ack");
    send_byte(8'h3F, "R5 data0 ack");
    send_byte(8'h15, "R5 data1 ack");
    send_byte(8'hAA, "R5 data2 ack");
    send_byte(8'h01, "R5 data3 ack");
    send_byte(8'h40, "R5 data4 ack");
    bus_stop();
    check(adj_at(0) == 'h3F, "R5 adj0", adj_at(0), 'h3F);
    check(adj_at(2) == 'h2A, "R4 adj2 low six bits", adj_at(2), 'h2A);
    check(adj_at(4) == 'h00, "R4 adj4 low six bits", adj_at(4), 'h00);

    // R4: auxiliary register
    bus_start();
    send_byte(8'h88, "R2 address ack");
    send_byte(8'h09, "R3 sub ack");
    send_byte(8'hA5, "R4 aux ack");
    bus_stop();
    check(ctl[15:8] == 8'hA5, "R4 aux value", int'(ctl[15:8]), 'hA5);

    // R7: unmapped sub-addresses
    snap_a = adj; snap_c = ctl;
    bus_start();
    send_byte(8'h88, "R2 address ack");
    send_byte(8'h0A, "R7 sub ack");
    send_byte(8'h12, "R7 unmapped data ack");
    send_byte(8'h13, "R7 unmapped data ack");
    bus_stop();
    check(adj == snap_a && ctl == snap_c, "R7 no change", int'(ctl), int'(snap_c));

    // R2: wrong address and read bit
    bus_start();
    send_byte(8'h8A, "R2 wrong address nack");
    send_byte(8'h00, "R2 ignored sub nack");
    send_byte(8'h11, "R2 ignored data nack");
    bus_stop();
    bus_start();
    send_byte(8'h89, "R2 read bit nack");
    send_byte(8'h00, "R2 ignored sub nack");
    bus_stop();
    check(adj_at(0) == 'h3F, "R2 adj0 unchanged", adj_at(0), 'h3F);

    // R6: auto-increment disabled
    bus_start();
    send_byte(8'h88, "R2 address ack");
    send_byte(8'h08, "R3 sub ack");
    send_byte(8'h01, "R9 mode ack");
    bus_stop();
    bus_start();
    send_byte(8'h88, "R2 address ack");
    send_byte(8'h03, "R3 sub ack");
    send_byte(8'h11, "R6 first data ack");
    send_byte(8'h22, "R6 second data nack");
    send_byte(8'h33, "R6 third data nack");
    bus_stop();
    check(adj_at(3) == 'h11, "R6 adj3 written", adj_at(3), 'h11);
    check(adj_at(4) == 'h00, "R6 adj4 untouched", adj_at(4), 'h00);

    // R8 R9: blanking-synchronised update
    bus_start();
    send_byte(8'h88, "R2 address ack");
    send_byte(8'h08, "R3 sub ack");
    send_byte(8'h02, "R9 mode ack");
    bus_stop();
    check(ctl[7:0] == 8'h02, "R9 mode applied", int'(ctl[7:0]), 'h02);
    bus_start();
    send_byte(8'h88, "R2 address ack");
    send_byte(8'h00, "R3 sub ack");
    send_byte(8'h05, "R8 staged ack");
    send_byte(8'h06, "R8 staged ack");
    bus_stop();
    bus_start();
    send_byte(8'h88, "R2 address ack");
    send_byte(8'h09, "R3 sub ack");
    send_byte(8'h77, "R8 staged aux ack");
    bus_stop();
    check(adj_at(0) == 'h3F, "R8 adj0 held", adj_at(0), 'h3F);
    check(ctl[15:8] == 8'hA5, "R8 aux held", int'(ctl[15:8]), 'hA5);
    bus_start();
    send_byte(8'h88, "R2 address ack");
    send_byte(8'h08, "R3 sub ack");
    send_byte(8'h03, "R9 mode while sync ack");
    bus_stop();
    check(ctl[7:0] == 8'h03, "R9 mode immediate under sync", int'(ctl[7:0]), 'h03);
    blank_pulse();
    check(adj_at(0) == 'h05, "R8 adj0 after blank", adj_at(0), 'h05);
    check(adj_at(1) == 'h06, "R8 adj1 after blank", adj_at(1), 'h06);
    check(ctl[15:8] == 8'h77, "R8 aux after blank", int'(ctl[15:8]), 'h77);
    bus_start();
    send_byte(8'h88, "R2 address ack");
    send_byte(8'h08, "R3 sub ack");
    send_byte(8'h00, "R9 mode clear ack");
    bus_stop();

    // R10: repeated start
    bus_start();
    send_byte(8'h88, "R2 address ack");
    send_byte(8'h01, "R3 sub ack");
    bus_start();
    send_byte(8'h88, "R10 address after restart ack");
    send_byte(8'h05, "R10 sub ack");
    send_byte(8'h09, "R10 data ack");
    bus_stop();
    check(adj_at(5) == 'h09, "R10 adj5", adj_at(5), 'h09);
    check(adj_at(1) == 'h06, "R10 adj1 untouched", adj_at(1), 'h06);
    bus_start();
    send_byte(8'h88, "R2 address ack");
    send_byte(8'h06, "R3 sub ack");
    send_byte(8'h2C, "R10 data ack");
    bus_start();
    send_byte(8'h07, "R10 byte as address nack");
    bus_start();
    send_byte(8'h88, "R10 address ack");
    send_byte(8'h07, "R10 sub ack");
    send_byte(8'h1B, "R10 data ack");
    bus_stop();
    check(adj_at(6) == 'h2C, "R10 adj6", adj_at(6), 'h2C);
    check(adj_at(7) == 'h1B, "R10 adj7", adj_at(7), 'h1B);

    // R1: bytes after stop without a start
    send_byte(8'h88, "R1 idle address nack");
    send_byte(8'h00, "R1 idle sub nack");
    send_byte(8'h3F, "R1 idle data nack");
    check(adj_at(0) == 'h05, "R1 adj0 unchanged", adj_at(0), 'h05);

    tick(20);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule